// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block sets the division ratio of a fractional-N PLL feedback path one cycle at a time and divides the oscillator-side clock by that ratio. It emits a single-cycle pulse toward the phase detector each time a count completes. The programmed integer part (`int_val`), numerator (`frac_val`) and modulus (`mod_val`) give an average ratio of INT + FRAC/MOD. A three-stage cascade of modulo-MOD accumulators (MASH 1-1-1) dithers the integer ratio by a small signed offset for each count. The carries of the three stages are combined as c1 + (c2 − c2') + (c3 − 2c3' + c3''), where a prime marks the value from the previous step.

The block is clocked by the oscillator-side clock, so one count unit is one clock cycle. A new ratio is computed and latched only at a counter reload, so a count already in progress is never cut short. The interpolator steps exactly once per reload. If `int_mode` is set and FRAC is zero, the accumulators are held clear and every count equals INT.

The block checks the programmed values against limits that depend on the prescaler selection. If any value is out of range, an error flag rises and the divider keeps reloading the last valid ratio, with the interpolator frozen, until the values become legal again.

The controller is a three-state machine:
- **IDLE** is the state after reset. It moves to RUN through transition START when the configuration is valid.
- **RUN** counts with interpolated ratios. It moves to HOLD through transition FAULT when a reload finds the configuration invalid.
- **HOLD** keeps reloading the held ratio. It returns to RUN through transition RECOVER when a reload finds the configuration valid.

Top module: `fracn_divider`

## Requirements
- R1: While in reset and until a valid configuration is first seen, `fb_pulse` is low and `ratio_now` is 0. During reset `cfg_err` is 0.
- R2: Outside IDLE, the number of clock cycles between two consecutive `fb_pulse` highs equals the `ratio_now` value shown on the second pulse. `ratio_now` changes only in the cycle after a pulse.
- R3: When `int_mode` = 1 and FRAC = 0, every applied ratio equals INT exactly.
- R4: Every applied ratio lies in INT−3 to INT+4.
- R5: After reset with a fixed valid configuration, the ratios on pulses number MOD³+1 through 2·MOD³ sum to exactly MOD²·(MOD·INT + FRAC).
- R6: The minimum legal INT is 23 when `presc_sel` = 0 and 75 when `presc_sel` = 1. A smaller INT sets `cfg_err` one cycle later.
- R7: FRAC ≥ MOD, or MOD < 2, sets `cfg_err` one cycle later.
- R8: While the configuration is invalid, pulses continue and each reload reuses the last valid ratio.
- R9: When the configuration becomes valid again, `cfg_err` clears one cycle later. The count that starts at the next reload uses the new values.
- R10: If the configuration is invalid from reset onward, no pulse is produced, `ratio_now` stays 0 and `cfg_err` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-side clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| int_val | input | IW (16) | Integer part of the ratio |
| frac_val | input | MW (12) | Fractional numerator |
| mod_val | input | MW (12) | Fractional modulus |
| presc_sel | input | 1 | 0: low-ratio prescaler (min INT 23), 1: high-ratio prescaler (min INT 75) |
| int_mode | input | 1 | Integer-only request, honoured when FRAC is 0 |
| fb_pulse | output | 1 | One-cycle pulse on the last cycle of each count |
| ratio_now | output | IW+1 (17) | Ratio of the count in progress, 0 before the first load |
| cfg_err | output | 1 | Registered out-of-range flag |

## Verification
A corrupted accumulator or carry delay does not change the pulse spacing's agreement with `ratio_now`, but it breaks the exact period sum. It is therefore only visible after a full MOD³ window of pulses, or at once if it pushes a ratio outside INT−3 to INT+4. A counter or state-register fault shows up on the very next pulse as a spacing that differs from `ratio_now`. A range-check fault appears as `cfg_err` one cycle after the input change, and as a wrong ratio on the second pulse after an error clears.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    // width of the signed per-count offset produced by the interpolator (-3..+4)
    localparam int OFF_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_HOLD
    } seq_state_e;

endpackage

// File: rtl/fracn_cfg_chk.sv
module fracn_cfg_chk #(
    parameter int IW       = 16,
    parameter int MW       = 12,
    parameter int MIN_N_LO = 23,
    parameter int MIN_N_HI = 75,
    parameter int MOD_MIN  = 2
) (
    input  logic [IW-1:0] int_val,
    input  logic [MW-1:0] frac_val,
    input  logic [MW-1:0] mod_val,
    input  logic          presc_sel,
    input  logic          int_mode,
    output logic          cfg_ok,
    output logic          int_only
);

    localparam logic [IW-1:0] LIM_LO  = IW'(MIN_N_LO);
    localparam logic [IW-1:0] LIM_HI  = IW'(MIN_N_HI);
    localparam logic [MW-1:0] LIM_MOD = MW'(MOD_MIN);

    logic int_ok;
    logic mod_ok;
    logic frac_ok;

    always_comb begin
        int_ok   = int_val >= (presc_sel ? LIM_HI : LIM_LO);
        mod_ok   = mod_val >= LIM_MOD;
        frac_ok  = frac_val < mod_val;
        cfg_ok   = int_ok && mod_ok && frac_ok;
        int_only = int_mode && (frac_val == '0);
    end

endmodule

// File: rtl/fracn_mash.sv
module fracn_mash
    import fracn_pkg::*;
#(
    parameter int MW = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    adv,
    input  logic [MW-1:0]           frac_val,
    input  logic [MW-1:0]           mod_val,
    output logic signed [OFF_W-1:0] offset
);

    localparam int STAGES = 3;

    // modulo add: {carry, residue}
    function automatic logic [MW:0] mod_add(input logic [MW-1:0] a,
                                            input logic [MW-1:0] b,
                                            input logic [MW-1:0] m);
        logic [MW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= {1'b0, m}) begin
            mod_add = {1'b1, MW'(s - {1'b0, m})};
        end else begin
            mod_add = {1'b0, s[MW-1:0]};
        end
    endfunction

    logic [MW-1:0] acc_q  [STAGES];
    logic [MW-1:0] acc_d  [STAGES];
    logic [MW-1:0] feed   [STAGES];
    logic          carry  [STAGES];
    logic          c2_d1;
    logic          c3_d1;
    logic          c3_d2;

    // stage k accumulates the fresh residue of stage k-1
    assign feed[0] = frac_val;

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_stage
            logic [MW:0] sum_k;
            assign sum_k    = mod_add(acc_q[k], feed[k], mod_val);
            assign carry[k] = sum_k[MW];
            assign acc_d[k] = sum_k[MW-1:0];
            if (k + 1 < STAGES) begin : g_link
                assign feed[k+1] = acc_d[k];
            end

            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    acc_q[k] <= '0;
                end else if (adv) begin
                    acc_q[k] <= acc_d[k];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            c2_d1 <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
        end else if (adv) begin
            c2_d1 <= carry[1];
            c3_d1 <= carry[2];
            c3_d2 <= c3_d1;
        end
    end

    // c1 + (c2 - c2') + (c3 - 2c3' + c3'') for the step being taken
    always_comb begin
        if (clr) begin
            offset = '0;
        end else begin
            offset = $signed(OFF_W'(carry[0]) + OFF_W'(carry[1]) + OFF_W'(carry[2])
                   + OFF_W'(c3_d2) - OFF_W'(c2_d1) - OFF_W'({c3_d1, 1'b0}));
        end
    end

endmodule

// File: rtl/fracn_seq.sv
module fracn_seq
    import fracn_pkg::*;
#(
    parameter int RW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_ok,
    input  logic [RW-1:0] cand,
    output logic          fb_pulse,
    output logic          adv,
    output logic [RW-1:0] ratio_q
);

    seq_state_e    state_q;
    seq_state_e    state_d;
    logic [RW-1:0] cnt_q;
    logic          reload;

    assign reload = (state_q != ST_IDLE) && (cnt_q == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: START, FAULT, RECOVER
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cfg_ok)            state_d = ST_RUN;
            ST_RUN:  if (reload && !cfg_ok) state_d = ST_HOLD;
            ST_HOLD: if (reload && cfg_ok)  state_d = ST_RUN;
            default:                        state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fb_pulse = reload;
        adv      = cfg_ok && ((state_q == ST_IDLE) || reload);
    end

    // count datapath: a ratio is taken only at a reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ratio_q <= '0;
        end else if (adv) begin
            cnt_q   <= cand - RW'(1);
            ratio_q <= cand;
        end else if (reload) begin
            cnt_q   <= ratio_q - RW'(1);
        end else if (state_q != ST_IDLE) begin
            cnt_q   <= cnt_q - RW'(1);
        end
    end

endmodule

// File: rtl/fracn_divider.sv
module fracn_divider
    import fracn_pkg::*;
#(
    parameter int IW       = 16,
    parameter int MW       = 12,
    parameter int MIN_N_LO = 23,
    parameter int MIN_N_HI = 75,
    parameter int RW       = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] int_val,
    input  logic [MW-1:0] frac_val,
    input  logic [MW-1:0] mod_val,
    input  logic          presc_sel,
    input  logic          int_mode,
    output logic          fb_pulse,
    output logic [RW-1:0] ratio_now,
    output logic          cfg_err
);

    logic                    cfg_ok;
    logic                    int_only;
    logic                    adv;
    logic signed [OFF_W-1:0] offset;
    logic [RW-1:0]           cand;

    fracn_cfg_chk #(
        .IW(IW), .MW(MW), .MIN_N_LO(MIN_N_LO), .MIN_N_HI(MIN_N_HI), .MOD_MIN(2)
    ) u_cfg (
        .int_val(int_val), .frac_val(frac_val), .mod_val(mod_val),
        .presc_sel(presc_sel), .int_mode(int_mode),
        .cfg_ok(cfg_ok), .int_only(int_only)
    );

    fracn_mash #(.MW(MW)) u_mash (
        .clk(clk), .rst_n(rst_n), .clr(int_only), .adv(adv),
        .frac_val(frac_val), .mod_val(mod_val), .offset(offset)
    );

    assign cand = RW'(int_val) + {{(RW-OFF_W){offset[OFF_W-1]}}, offset};

    fracn_seq #(.RW(RW)) u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_ok(cfg_ok), .cand(cand),
        .fb_pulse(fb_pulse), .adv(adv), .ratio_q(ratio_now)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= !cfg_ok;
        end
    end

endmodule

// File: rtl/fracn_divider_chk.sv
module fracn_divider_chk #(
    parameter int IW = 16,
    parameter int MW = 12,
    parameter int RW = IW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [IW-1:0] int_val,
    input logic [MW-1:0] frac_val,
    input logic          presc_sel,
    input logic          int_mode,
    input logic          fb_pulse,
    input logic [RW-1:0] ratio_now,
    input logic          cfg_err,
    input logic          cfg_ok
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_now == '0) |-> !fb_pulse);

    a_r2_ratio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fb_pulse && ratio_now != '0) |=> $stable(ratio_now));

    a_r3_int_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_pulse && cfg_ok && int_mode && frac_val == '0)
        |=> ratio_now == RW'($past(int_val)));

    a_r4_ratio_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_pulse && cfg_ok)
        |=> (ratio_now + RW'(3) >= RW'($past(int_val)))
            && (ratio_now <= RW'($past(int_val)) + RW'(4)));

    a_r6_min_int_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_sel && int_val < IW'(75)) |=> cfg_err);

    a_r6_min_int_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (!presc_sel && int_val < IW'(23)) |=> cfg_err);

    a_r8_hold_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_pulse && !cfg_ok) |=> $stable(ratio_now));

    a_r9_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ok |=> !cfg_err);

endmodule

bind fracn_divider fracn_divider_chk #(.IW(IW), .MW(MW), .RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .int_val(int_val), .frac_val(frac_val),
    .presc_sel(presc_sel), .int_mode(int_mode), .fb_pulse(fb_pulse),
    .ratio_now(ratio_now), .cfg_err(cfg_err), .cfg_ok(cfg_ok)
);

// File: tb/test_fracn_divider.sv
module test_fracn_divider;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] int_val = 16'd23;
    logic [11:0] frac_val = '0;
    logic [11:0] mod_val = 12'd2;
    logic        presc_sel = 1'b0;
    logic        int_mode = 1'b1;
    logic        fb_pulse;
    logic [16:0] ratio_now;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    string tag_q[$];
    int log_q[$];
    longint cyc = 0;
    longint prev_cyc = 0;
    bit have_prev = 0;

    always #10 clk = ~clk;

    fracn_divider i_fracn_divider (
        .clk(clk), .rst_n(rst_n), .int_val(int_val), .frac_val(frac_val),
        .mod_val(mod_val), .presc_sel(presc_sel), .int_mode(int_mode),
        .fb_pulse(fb_pulse), .ratio_now(ratio_now), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: spacing check and scoreboard compare on every pulse
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            have_prev = 0;
        end else if (fb_pulse) begin
            if (have_prev) check((cyc - prev_cyc) == longint'(ratio_now), "R2 spacing",
                                 cyc - prev_cyc, ratio_now);
            prev_cyc  = cyc;
            have_prev = 1;
            log_q.push_back(int'(ratio_now));
            if (exp_q.size() > 0) begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(int'(ratio_now) == e, t, ratio_now, e);
            end
        end
    end

    task automatic push_exp(input int r, input int n, input string t);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(r);
            tag_q.push_back(t);
        end
    endtask

    task automatic apply_reset(input int iv, input int fv, input int mv, input bit ps, input bit im);
        @(negedge clk);
        rst_n = 1'b0;
        int_val = 16'(iv); frac_val = 12'(fv); mod_val = 12'(mv);
        presc_sel = ps; int_mode = im;
        exp_q.delete(); tag_q.delete(); log_q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_pulses(input int n);
        while (log_q.size() < n) @(negedge clk);
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic skip_pulse();
        @(negedge clk);
        while (!fb_pulse) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic frac_window(input int iv, input int fv, input int mv);
        int per;
        longint sum;
        per = mv * mv * mv;
        apply_reset(iv, fv, mv, 1'b0, 1'b0);
        wait_pulses(2 * per);
        sum = 0;
        for (int i = 0; i < 2 * per; i++) begin
            check(log_q[i] >= iv - 3 && log_q[i] <= iv + 4, "R4 bound", log_q[i], iv);
            if (i >= per) sum += log_q[i];
        end
        check(sum == longint'(mv) * mv * (mv * iv + fv), "R5 period sum",
              sum, longint'(mv) * mv * (mv * iv + fv));
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check(fb_pulse == 1'b0, "R1 pulse in reset", fb_pulse, 0);
        check(ratio_now == '0, "R1 ratio in reset", ratio_now, 0);
        check(cfg_err == 1'b0, "R1 err in reset", cfg_err, 0);

        // R3: pure integer divide, lowest legal INT with presc_sel=0 (R6)
        push_exp(23, 10, "R3 integer");
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_err == 1'b0, "R6 INT 23 legal low prescaler", cfg_err, 0);
        drain();

        // R4/R5: fractional runs
        frac_window(25, 2, 3);
        frac_window(30, 3, 5);

        // R8/R9/R6: error hold and recovery
        apply_reset(50, 0, 4, 1'b0, 1'b1);
        wait_pulses(2);
        @(negedge clk);
        presc_sel = 1'b1;
        @(negedge clk);
        check(cfg_err == 1'b1, "R6 INT 50 illegal high prescaler", cfg_err, 1);
        push_exp(50, 3, "R8 held ratio");
        drain();
        @(negedge clk);
        int_val = 16'd75;
        @(negedge clk);
        check(cfg_err == 1'b0, "R9 err clears", cfg_err, 0);
        skip_pulse();
        push_exp(75, 3, "R9 new ratio");
        drain();

        // R7: fraction and modulus limits
        @(negedge clk);
        frac_val = 12'd4;
        @(negedge clk);
        check(cfg_err == 1'b1, "R7 FRAC equal MOD", cfg_err, 1);
        frac_val = 12'd0;
        @(negedge clk);
        check(cfg_err == 1'b0, "R7 FRAC 0 legal", cfg_err, 0);
        mod_val = 12'd1;
        @(negedge clk);
        check(cfg_err == 1'b1, "R7 MOD 1", cfg_err, 1);
        push_exp(75, 3, "R8 held under MOD fault");
        drain();

        // R6: low prescaler lower limit
        @(negedge clk);
        mod_val = 12'd4; presc_sel = 1'b0; int_val = 16'd22;
        @(negedge clk);
        check(cfg_err == 1'b1, "R6 INT 22 illegal low prescaler", cfg_err, 1);

        // R10: invalid from reset
        apply_reset(22, 0, 4, 1'b0, 1'b1);
        repeat (200) @(negedge clk);
        check(log_q.size() == 0, "R10 no pulses", log_q.size(), 0);
        check(ratio_now == '0, "R10 ratio stays 0", ratio_now, 0);
        check(cfg_err == 1'b1, "R10 err set", cfg_err, 1);

        summary();
        $finish;
    end

endmodule